// File: doc/BRIEF.md
# DS0 Test Pattern Generator and Checker

This block inserts a test sequence into the payload of a DS-1 bit stream and checks a sequence carried by a received stream. The framer supplies one strobe per bit time, together with the framing-bit flag, the DS0 channel number and the bit position within the channel. Only selected bit positions carry the pattern. All other positions, including the framing bit, pass through unchanged and do not advance either sequence.

The sequence is either a pseudo-random one (a 15-stage or a 20-stage shift register) or a programmable word of 1 to 32 bits that repeats. The pattern can fill the whole payload or only the channels whose enable bit is set. An Nx56 mode keeps the least significant bit of every channel out of the pattern.

The checker locks by loading its register from received bits. It then counts bit errors in a saturating counter that the host can clear. One instance serves one direction. A framer places one instance on its egress stream and another on its ingress stream, each fed by the timing strobes of its own direction.

Top module: `ds0_pattern_engine`

## Requirements
- R1: A bit position is selected when `slot_valid` is 1, `is_fbit` is 0, and either `cfg_full_payload` is 1 or bit `chan_idx` of `cfg_chan_en` is 1. A framing bit is never selected.
- R2: When `cfg_56k` is 1, bit position 7 (the least significant bit; position 0 is the most significant) of every channel is not selected.
- R3: On an unselected position, `tx_out` equals `tx_in`, and neither the generator state nor the checker state (lock, history, counters) changes.
- R4: With `cfg_repeat`=0 and `cfg_poly20`=0, each selected `tx_out` bit is the XOR of stages 15 and 14 of a 15-stage register. That bit is then shifted into stage 1. The register is all ones after reset.
- R5: With `cfg_repeat`=0 and `cfg_poly20`=1, the same rule holds with stages 20 and 17 of a 20-stage register that is all ones after reset.
- R6: With `cfg_repeat`=1, the selected bits are `cfg_rep_word[0]`, `[1]`, and so on up to `[cfg_rep_len]`, then the sequence restarts at bit 0. The period is `cfg_rep_len`+1.
- R7: While unlocked, the checker predicts each bit from the received bits (the same PRBS rule, or the bit received one period earlier in repeat mode). `sync` rises after 48 consecutive selected bits that match the prediction. While locked, the checker's history advances with predicted bits.
- R8: Once locked, selected bits are grouped into windows of 64 that start at lock. `sync` falls on the bit that brings the error count within the current window to 6.
- R9: A selected bit that mismatches while `sync` is 1 (before that bit) adds one to `err_count`. Mismatches while unlocked add nothing.
- R10: `err_count` stops at its all-ones value and does not wrap.
- R11: An `err_clear` pulse sets `err_count` to 0 on the next clock. A clear takes priority over an increment.
- R12: After reset, `sync` is 0 and `err_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_valid | input | 1 | A bit is present this cycle |
| is_fbit | input | 1 | The present bit is the framing bit |
| chan_idx | input | 5 | DS0 channel number, 0 to 23 |
| bit_idx | input | 3 | Bit position in the channel, 0 = most significant |
| cfg_full_payload | input | 1 | Pattern in every payload channel |
| cfg_chan_en | input | 24 | Per-channel pattern enable |
| cfg_56k | input | 1 | Exclude the least significant bit of each channel |
| cfg_repeat | input | 1 | 1 = repeating word, 0 = pseudo-random |
| cfg_poly20 | input | 1 | 1 = 20-stage register, 0 = 15-stage |
| cfg_rep_word | input | 32 | Repeating word, bit 0 sent first |
| cfg_rep_len | input | 5 | Repeat period minus one |
| tx_in | input | 1 | Stream bit before insertion |
| tx_out | output | 1 | Stream bit after insertion |
| rx_in | input | 1 | Received stream bit to check |
| err_clear | input | 1 | Clear the error counter |
| sync | output | 1 | Checker locked |
| err_count | output | 32 | Saturating bit-error count |

## Verification
The bench aims at the places where the two sequences must stand still.

- **Framing bits and masked positions.** Framing bits and masked channel positions are placed between pattern bits, with forced garbage on the receive side. A design that advanced its state on these positions would shift the transmitted sequence, or would never reach lock at exactly the 48th selected bit.
- **Window edges.** Errors are placed just inside and just past a 64-bit window boundary: five errors in one window, then six in the next. An off-by-one window or threshold would drop lock too early or never.
- **Counting rules.** Errors sent while unlocked must not count.
- **Saturation.** A second instance with a 4-bit counter takes 20 errors. A wrapping counter would read 4 instead of 15.

// File: rtl/pat_pkg.sv
package pat_pkg;
    localparam int PAT_LFSR_W = 20;
    localparam int PAT_REP_W  = 32;
    localparam int PAT_PTR_W  = $clog2(PAT_REP_W);

    typedef enum logic {
        SEQ_PRBS   = 1'b0,
        SEQ_REPEAT = 1'b1
    } seq_kind_e;

    typedef struct packed {
        logic [PAT_LFSR_W-1:0] lfsr;
        logic [PAT_PTR_W-1:0]  ptr;
    } gen_state_t;
endpackage

// File: rtl/pat_slot_sel.sv
module pat_slot_sel #(
    parameter int CHANNELS = 24,
    parameter int CH_W     = 5
) (
    input  logic                slot_valid,
    input  logic                is_fbit,
    input  logic [CH_W-1:0]     chan_idx,
    input  logic [2:0]          bit_idx,
    input  logic                full_payload,
    input  logic [CHANNELS-1:0] chan_en,
    input  logic                skip_lsb,
    output logic                sel
);
    logic [CHANNELS-1:0] hit_vec;

    generate
        for (genvar g = 0; g < CHANNELS; g++) begin : g_chan
            assign hit_vec[g] = chan_en[g] && (chan_idx == CH_W'(g));
        end
    endgenerate

    always_comb begin
        sel = slot_valid && !is_fbit && (full_payload || (|hit_vec));
        if (skip_lsb && bit_idx == 3'd7) begin
            sel = 1'b0;
        end
    end
endmodule

// File: rtl/pat_gen.sv
module pat_gen
    import pat_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel,
    input  seq_kind_e             kind,
    input  logic                  poly20,
    input  logic [PAT_REP_W-1:0]  rep_word,
    input  logic [PAT_PTR_W-1:0]  rep_len,
    output logic                  pat_bit
);
    gen_state_t st_q, st_d;
    logic       fb;

    always_comb begin
        fb = poly20 ? (st_q.lfsr[19] ^ st_q.lfsr[16])
                    : (st_q.lfsr[14] ^ st_q.lfsr[13]);
        pat_bit = (kind == SEQ_PRBS) ? fb : rep_word[st_q.ptr];
        st_d = st_q;
        if (sel) begin
            if (kind == SEQ_PRBS) begin
                st_d.lfsr = {st_q.lfsr[PAT_LFSR_W-2:0], fb};
            end else if (st_q.ptr >= rep_len) begin
                st_d.ptr = '0;
            end else begin
                st_d.ptr = st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lfsr <= '1;
            st_q.ptr  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: unselected positions leave the generator untouched
    a_r3_gen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(st_q));
    // R6: the repeat pointer never runs past the programmed period
    a_r6_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SEQ_REPEAT && sel && st_q.ptr >= rep_len) |=> st_q.ptr == '0);
endmodule

// File: rtl/pat_chk.sv
module pat_chk
    import pat_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int SYNC_GOOD = 48,
    parameter int WIN_LEN   = 64,
    parameter int LOS_ERRS  = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 rx_bit,
    input  seq_kind_e            kind,
    input  logic                 poly20,
    input  logic [PAT_PTR_W-1:0] rep_len,
    input  logic                 clear,
    output logic                 sync,
    output logic [CNT_W-1:0]     err_count
);
    localparam int GOOD_W = $clog2(SYNC_GOOD + 1);
    localparam int WIN_W  = $clog2(WIN_LEN);
    localparam int ERR_W  = $clog2(LOS_ERRS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [PAT_REP_W-1:0] hist;
        logic                 locked;
        logic [GOOD_W-1:0]    good;
        logic [WIN_W-1:0]     win;
        logic [ERR_W-1:0]     werr;
        logic [CNT_W-1:0]     cnt;
    } chk_state_t;

    chk_state_t st_q, st_d;
    logic       expect_bit;
    logic       mismatch;
    logic       shift_bit;
    logic [ERR_W-1:0] werr_next;

    always_comb begin
        if (kind == SEQ_PRBS) begin
            expect_bit = poly20 ? (st_q.hist[19] ^ st_q.hist[16])
                                : (st_q.hist[14] ^ st_q.hist[13]);
        end else begin
            expect_bit = st_q.hist[rep_len];
        end
        mismatch  = rx_bit ^ expect_bit;
        shift_bit = st_q.locked ? expect_bit : rx_bit;
        werr_next = st_q.werr + ERR_W'(mismatch);

        st_d = st_q;
        if (sel) begin
            st_d.hist = {st_q.hist[PAT_REP_W-2:0], shift_bit};
            if (!st_q.locked) begin
                if (mismatch) begin
                    st_d.good = '0;
                end else if (st_q.good == GOOD_W'(SYNC_GOOD - 1)) begin
                    st_d.locked = 1'b1;
                    st_d.good   = '0;
                    st_d.win    = '0;
                    st_d.werr   = '0;
                end else begin
                    st_d.good = st_q.good + 1'b1;
                end
            end else begin
                if (mismatch && st_q.cnt != CNT_MAX) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
                if (werr_next >= ERR_W'(LOS_ERRS)) begin
                    st_d.locked = 1'b0;
                    st_d.good   = '0;
                    st_d.win    = '0;
                    st_d.werr   = '0;
                end else if (st_q.win == WIN_W'(WIN_LEN - 1)) begin
                    st_d.win  = '0;
                    st_d.werr = '0;
                end else begin
                    st_d.win  = st_q.win + 1'b1;
                    st_d.werr = werr_next;
                end
            end
        end
        if (clear) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.hist   <= '1;
            st_q.locked <= 1'b0;
            st_q.good   <= '0;
            st_q.win    <= '0;
            st_q.werr   <= '0;
            st_q.cnt    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync      = st_q.locked;
    assign err_count = st_q.cnt;

    // R10: a full counter stays full
    a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count == CNT_MAX && !clear) |=> err_count == CNT_MAX);
    // R11: clear empties the counter on the next clock
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> err_count == '0);
    // R9: nothing is counted while unlocked
    a_r9_unlocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync && !clear) |=> $stable(err_count));
    // R3: unselected positions leave lock and history alone
    a_r3_chk_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> ($stable(sync) && $stable(st_q.hist)));
endmodule

// File: rtl/ds0_pattern_engine.sv
module ds0_pattern_engine
    import pat_pkg::*;
#(
    parameter int CHANNELS  = 24,
    parameter int CNT_W     = 32,
    parameter int SYNC_GOOD = 48,
    parameter int WIN_LEN   = 64,
    parameter int LOS_ERRS  = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 slot_valid,
    input  logic                 is_fbit,
    input  logic [4:0]           chan_idx,
    input  logic [2:0]           bit_idx,
    input  logic                 cfg_full_payload,
    input  logic [CHANNELS-1:0]  cfg_chan_en,
    input  logic                 cfg_56k,
    input  logic                 cfg_repeat,
    input  logic                 cfg_poly20,
    input  logic [31:0]          cfg_rep_word,
    input  logic [4:0]           cfg_rep_len,
    input  logic                 tx_in,
    output logic                 tx_out,
    input  logic                 rx_in,
    input  logic                 err_clear,
    output logic                 sync,
    output logic [CNT_W-1:0]     err_count
);
    logic      sel;
    logic      gen_bit;
    seq_kind_e kind;

    assign kind = cfg_repeat ? SEQ_REPEAT : SEQ_PRBS;

    pat_slot_sel #(.CHANNELS(CHANNELS), .CH_W(5)) u_sel (
        .slot_valid   (slot_valid),
        .is_fbit      (is_fbit),
        .chan_idx     (chan_idx),
        .bit_idx      (bit_idx),
        .full_payload (cfg_full_payload),
        .chan_en      (cfg_chan_en),
        .skip_lsb     (cfg_56k),
        .sel          (sel)
    );

    pat_gen u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .kind     (kind),
        .poly20   (cfg_poly20),
        .rep_word (cfg_rep_word),
        .rep_len  (cfg_rep_len),
        .pat_bit  (gen_bit)
    );

    pat_chk #(
        .CNT_W     (CNT_W),
        .SYNC_GOOD (SYNC_GOOD),
        .WIN_LEN   (WIN_LEN),
        .LOS_ERRS  (LOS_ERRS)
    ) u_chk (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .rx_bit    (rx_in),
        .kind      (kind),
        .poly20    (cfg_poly20),
        .rep_len   (cfg_rep_len),
        .clear     (err_clear),
        .sync      (sync),
        .err_count (err_count)
    );

    assign tx_out = sel ? gen_bit : tx_in;

    // R1: a framing bit always leaves the stream untouched
    a_r1_fbit_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && is_fbit) |-> tx_out == tx_in);
    // R2: in Nx56 mode the channel LSB is never overwritten
    a_r2_lsb_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && cfg_56k && bit_idx == 3'd7) |-> tx_out == tx_in);
endmodule

// File: tb/ds0_pattern_engine_tb_top.sv
module ds0_pattern_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_valid = 1'b0, is_fbit = 1'b0;
    logic [4:0]  chan_idx = '0;
    logic [2:0]  bit_idx = '0;
    logic        cfg_full_payload = 1'b0;
    logic [23:0] cfg_chan_en = '0;
    logic        cfg_56k = 1'b0, cfg_repeat = 1'b0, cfg_poly20 = 1'b0;
    logic [31:0] cfg_rep_word = '0;
    logic [4:0]  cfg_rep_len = '0;
    logic        tx_in = 1'b0, err_clear = 1'b0;
    logic        rx_inj = 1'b0, rx_force = 1'b0, rx_force_val = 1'b0;
    logic        tx_out, rx_in, sync, sat_tx, sat_sync;
    logic [31:0] err_count;
    logic [3:0]  sat_count;
    logic [19:0] rs;
    int          n_checks = 0;
    int          n_errs = 0;

    always #2 clk = ~clk;

    assign rx_in = rx_force ? rx_force_val : (tx_out ^ rx_inj);

    ds0_pattern_engine dut_i (
        .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .is_fbit(is_fbit),
        .chan_idx(chan_idx), .bit_idx(bit_idx), .cfg_full_payload(cfg_full_payload),
        .cfg_chan_en(cfg_chan_en), .cfg_56k(cfg_56k), .cfg_repeat(cfg_repeat),
        .cfg_poly20(cfg_poly20), .cfg_rep_word(cfg_rep_word), .cfg_rep_len(cfg_rep_len),
        .tx_in(tx_in), .tx_out(tx_out), .rx_in(rx_in), .err_clear(err_clear),
        .sync(sync), .err_count(err_count)
    );

    ds0_pattern_engine #(.CNT_W(4)) sat_i (
        .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .is_fbit(is_fbit),
        .chan_idx(chan_idx), .bit_idx(bit_idx), .cfg_full_payload(cfg_full_payload),
        .cfg_chan_en(cfg_chan_en), .cfg_56k(cfg_56k), .cfg_repeat(cfg_repeat),
        .cfg_poly20(cfg_poly20), .cfg_rep_word(cfg_rep_word), .cfg_rep_len(cfg_rep_len),
        .tx_in(tx_in), .tx_out(sat_tx), .rx_in(rx_in), .err_clear(err_clear),
        .sync(sat_sync), .err_count(sat_count)
    );

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ref_bit(input logic p20, output logic o);
        o  = p20 ? (rs[19] ^ rs[16]) : (rs[14] ^ rs[13]);
        rs = {rs[18:0], o};
    endtask

    task automatic reset_dut();
        rst_n = 1'b0;
        slot_valid = 1'b0; is_fbit = 1'b0; err_clear = 1'b0;
        rx_inj = 1'b0; rx_force = 1'b0;
        cfg_full_payload = 1'b0; cfg_chan_en = '0; cfg_56k = 1'b0;
        cfg_repeat = 1'b0; cfg_poly20 = 1'b0; cfg_rep_word = '0; cfg_rep_len = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        rs = '1;
    endtask

    task automatic step(input logic f, input int ch, input int b, input logic tin,
                        input logic inj, input logic frc, output logic txo);
        slot_valid = 1'b1; is_fbit = f; chan_idx = 5'(ch); bit_idx = 3'(b);
        tx_in = tin; rx_inj = inj; rx_force = frc; rx_force_val = ~tin;
        #1 txo = tx_out;
        @(posedge clk);
        #1 slot_valid = 1'b0; rx_inj = 1'b0; rx_force = 1'b0;
    endtask

    task automatic pay(input int k, input logic inj, output logic txo);
        step(1'b0, (k / 8) % 24, k % 8, k[0] ^ k[2], inj, 1'b0, txo);
    endtask

    task automatic t_reset();
        logic t;
        reset_dut();
        check(sync == 1'b0, "R12 sync after reset", sync, 0);
        check(err_count == 0, "R12 count after reset", err_count, 0);
        step(1'b0, 2, 1, 1'b1, 1'b0, 1'b0, t);
        check(t == 1'b1, "R3 disabled channel passes", t, 1);
    endtask

    task automatic t_prbs(input logic p20);
        logic t, e;
        int bad = 0;
        reset_dut();
        cfg_full_payload = 1'b1; cfg_poly20 = p20;
        for (int k = 0; k < 80; k++) begin
            if (k == 30) begin
                step(1'b1, 0, 0, 1'b1, 1'b0, 1'b0, t);
                check(t == 1'b1, "R1 framing bit passes", t, 1);
            end
            pay(k, 1'b0, t);
            ref_bit(p20, e);
            if (t !== e) bad++;
        end
        check(bad == 0, p20 ? "R5 PRBS20 sequence" : "R4 PRBS15 sequence", bad, 0);
    endtask

    task automatic t_mask();
        logic t, e;
        int bad = 0;
        reset_dut();
        cfg_chan_en = 24'h000008;
        for (int ch = 0; ch < 6; ch++) begin
            for (int b = 0; b < 8; b++) begin
                step(1'b0, ch, b, 1'((ch + b) % 2), 1'b0, 1'b0, t);
                if (ch == 3) begin
                    ref_bit(1'b0, e);
                    if (t !== e) bad++;
                end else if (t !== 1'((ch + b) % 2)) begin
                    bad++;
                end
            end
        end
        check(bad == 0, "R1 R3 channel enable mask", bad, 0);
        reset_dut();
        cfg_full_payload = 1'b1; cfg_56k = 1'b1;
        bad = 0;
        for (int k = 0; k < 32; k++) begin
            step(1'b0, 0, k % 8, k[1], 1'b0, 1'b0, t);
            if (k % 8 == 7) begin
                if (t !== k[1]) bad++;
            end else begin
                ref_bit(1'b0, e);
                if (t !== e) bad++;
            end
        end
        check(bad == 0, "R2 Nx56 LSB skipped", bad, 0);
    endtask

    task automatic t_repeat();
        logic t;
        int bad = 0;
        reset_dut();
        cfg_full_payload = 1'b1; cfg_repeat = 1'b1;
        cfg_rep_word = 32'h000000A5; cfg_rep_len = 5'd7;
        for (int k = 0; k < 120; k++) begin
            pay(k, 1'b0, t);
            if (k < 24 && t !== cfg_rep_word[k % 8]) bad++;
        end
        check(bad == 0, "R6 repeat word order", bad, 0);
        check(sync == 1'b1, "R7 repeat lock", sync, 1);
        check(err_count == 0, "R9 no count before lock", err_count, 0);
        reset_dut();
        cfg_full_payload = 1'b1; cfg_repeat = 1'b1;
        cfg_rep_word = 32'h00000006; cfg_rep_len = 5'd2;
        bad = 0;
        for (int k = 0; k < 9; k++) begin
            pay(k, 1'b0, t);
            if (t !== cfg_rep_word[k % 3]) bad++;
        end
        check(bad == 0, "R6 three-bit period", bad, 0);
    endtask

    task automatic t_sync_loss();
        logic t;
        reset_dut();
        cfg_full_payload = 1'b1;
        for (int k = 0; k < 47; k++) begin
            if (k % 10 == 3) step(1'b1, 0, 0, 1'b0, 1'b0, 1'b1, t);
            pay(k, 1'b0, t);
        end
        check(sync == 1'b0, "R7 not locked at 47", sync, 0);
        pay(47, 1'b0, t);
        check(sync == 1'b1, "R7 locked at 48", sync, 1);
        for (int j = 0; j < 80; j++) begin
            logic inj;
            inj = (j == 5 || j == 10 || j == 15 || j == 20 || j == 25 ||
                   (j >= 70));
            pay(48 + j, inj, t);
            if (j == 15) check(err_count == 3, "R9 three errors", err_count, 3);
            if (j == 63) check(sync == 1'b1, "R8 five errors keep lock", sync, 1);
            if (j == 74) check(sync == 1'b1, "R8 lock before sixth", sync, 1);
            if (j == 75) begin
                check(sync == 1'b0, "R8 sixth error drops lock", sync, 0);
                check(err_count == 11, "R9 count at loss", err_count, 11);
            end
        end
        check(err_count == 11, "R9 unlocked errors ignored", err_count, 11);
        err_clear = 1'b1;
        @(posedge clk);
        #1 err_clear = 1'b0;
        check(err_count == 0, "R11 clear", err_count, 0);
    endtask

    task automatic t_saturate();
        logic t;
        reset_dut();
        cfg_full_payload = 1'b1;
        for (int k = 0; k < 48; k++) pay(k, 1'b0, t);
        for (int j = 0; j < 400; j++) pay(48 + j, (j % 20 == 10), t);
        check(sync == 1'b1, "R8 sparse errors keep lock", sync, 1);
        check(err_count == 20, "R9 twenty errors", err_count, 20);
        check(sat_count == 4'hF, "R10 saturation", sat_count, 15);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        t_reset();
        t_prbs(1'b0);
        t_prbs(1'b1);
        t_mask();
        t_repeat();
        t_sync_loss();
        t_saturate();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule